// File: doc/BRIEF.md
# Smart Card Contact Power Sequencer

This block drives the four contact controls of one ISO-7816-3 card slot: supply enable, reset, clock enable and data-line enable. When the host asks for a start, the card is inserted and no fault is pending, it brings the contacts up in a fixed order. When the host asks for a stop, the card is pulled out or any protection input fires, it takes them down in the reverse order. Each downward step is held apart from the next by a parameter number of clock cycles.

Fault inputs arrive already synchronised from the comparators. Each source keeps a sticky flag that the host clears by a status read once the condition has gone. An active-low interrupt tells the host about faults and about card insertion or removal. The supply voltage choice (3 V or 5 V) is captured when a start is accepted.

Top module: `card_seq_top`

## Requirements
- R1: After reset, vcc_en, io_en, clk_en, card_rst, vcc_5v, card_active and fault_flags are all 0, and irq_n is 1.
- R2: A start_req pulse is accepted only from the idle state, and only when card_present is 1, no fault input is high and no fault flag is set. In any other case it has no effect.
- R3: Power-up order: vcc_en rises the edge after an accepted start. io_en rises the edge after vcc_good is seen high. clk_en rises GAP_CYC cycles after io_en. card_rst rises RST_DLY cycles after clk_en.
- R4: vcc_5v takes the value of vsel_5v at the edge where a start is accepted, and holds it while vcc_en stays high.
- R5: While powered up and not yet shutting down, any of stop_req, card_present low or a fault input high starts shutdown. card_rst is low after the next edge.
- R6: Shutdown order: card_rst falls first, clk_en falls GAP_CYC cycles later, io_en falls GAP_CYC cycles after that, and vcc_en falls GAP_CYC cycles after that. The default of 64 cycles exceeds 0.5 us at 125 MHz.
- R7: Once shutdown has begun, start_req, stop_req, faults and presence changes do not alter its timing, and the block does not restart until it reaches idle.
- R8: fault_flags bit 0 is over-current, bit 1 digital supply, bit 2 regulator input supply, bit 3 card supply and bit 4 over-temperature. A flag is set while its input is high. It clears on a status_rd cycle only if its input is low in that cycle.
- R9: irq_n goes low the edge after any fault input is high or card_present changes. It returns high on a status_rd cycle in which no such event occurs.
- R10: card_active is 1 from the edge after an accepted start until the edge at which vcc_en falls at the end of shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Host start command, one-cycle pulse |
| stop_req | input | 1 | Host stop command, one-cycle pulse |
| card_present | input | 1 | Card inserted (1) |
| vsel_5v | input | 1 | Supply choice: 1 = 5 V, 0 = 3 V |
| vcc_good | input | 1 | Card supply within range |
| flt_overcur | input | 1 | Card over-current fault |
| flt_vdd | input | 1 | Digital supply fault |
| flt_vpc | input | 1 | Regulator input supply fault |
| flt_vcc | input | 1 | Card supply fault |
| flt_hot | input | 1 | Over-temperature fault |
| status_rd | input | 1 | Host status read strobe |
| vcc_en | output | 1 | Card supply enable |
| vcc_5v | output | 1 | Latched supply choice |
| io_en | output | 1 | Data line released (0 = driven low) |
| clk_en | output | 1 | Card clock running |
| card_rst | output | 1 | Card reset line level |
| card_active | output | 1 | Card powered or shutting down |
| fault_flags | output | 5 | Sticky per-source fault flags |
| irq_n | output | 1 | Active-low host interrupt |

## Verification
The hardest cases to reach are shutdowns that begin part way through power-up, before clock or reset have risen, and new triggers that land inside a shutdown gap. The stimulus holds vcc_good low to park the block in its supply wait, then issues a stop. It pulses a card-supply fault while the reset delay is still counting. It also keeps card_present low and pulses start during an ongoing shutdown. A behavioural model tracks every output each cycle. Directed checks measure the gap between falling edges.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_IOREL,
    ST_CLKON,
    ST_ACTIVE,
    ST_DN_RST,
    ST_DN_CLK,
    ST_DN_IO
  } seq_st_t;

  localparam int NFLT     = 5;
  localparam int FI_OVC   = 0;
  localparam int FI_VDD   = 1;
  localparam int FI_VPC   = 2;
  localparam int FI_VCC   = 3;
  localparam int FI_HOT   = 4;
endpackage

// File: rtl/cs_step_timer.sv
module cs_step_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] last,
  output logic          done
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == last);
endmodule

// File: rtl/cs_fault_mon.sv
module cs_fault_mon #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] flt_raw,
  input  logic          card_present,
  input  logic          status_rd,
  output logic [NF-1:0] flags,
  output logic          any_raw,
  output logic          any_lat,
  output logic          irq_n
);
  logic pres_q;
  logic evt;

  assign any_raw = |flt_raw;
  assign any_lat = |flags;
  assign evt     = any_raw | (card_present ^ pres_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      irq_n  <= 1'b1;
      pres_q <= card_present;
    end else begin
      flags  <= flt_raw | (flags & {NF{~status_rd}});
      irq_n  <= ~(evt | (~irq_n & ~status_rd));
      pres_q <= card_present;
    end
  end

  generate
    for (genvar g = 0; g < NF; g++) begin : g_flag_chk
      p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flags[g] && !status_rd) |=> flags[g]);
      p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
        flt_raw[g] |=> flags[g]);
    end
  endgenerate

  p_irq_on_fault_r9: assert property (@(posedge clk) disable iff (rst)
    any_raw |=> !irq_n);
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import cs_pkg::*;
#(
  parameter int GAP_CYC = 64,
  parameter int RST_DLY = 400,
  parameter int CW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          card_present,
  input  logic          vsel_5v,
  input  logic          vcc_good,
  input  logic          any_raw,
  input  logic          any_lat,
  input  logic          tmr_done,
  output logic          tmr_restart,
  output logic [CW-1:0] tmr_last,
  output logic          vcc_en,
  output logic          vcc_5v,
  output logic          io_en,
  output logic          clk_en,
  output logic          card_rst,
  output logic          card_active
);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_DLY - 1);

  seq_st_t st_q, st_d;
  logic    abort_w;
  logic    start_ok;

  assign abort_w  = stop_req | ~card_present | any_raw;
  assign start_ok = start_req & card_present & ~any_raw & ~any_lat;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (start_ok) st_d = ST_PWR;
      ST_PWR: begin
        if (abort_w)       st_d = ST_DN_RST;
        else if (vcc_good) st_d = ST_IOREL;
      end
      ST_IOREL: begin
        if (abort_w)       st_d = ST_DN_RST;
        else if (tmr_done) st_d = ST_CLKON;
      end
      ST_CLKON: begin
        if (abort_w)       st_d = ST_DN_RST;
        else if (tmr_done) st_d = ST_ACTIVE;
      end
      ST_ACTIVE: if (abort_w)  st_d = ST_DN_RST;
      ST_DN_RST: if (tmr_done) st_d = ST_DN_CLK;
      ST_DN_CLK: if (tmr_done) st_d = ST_DN_IO;
      ST_DN_IO:  if (tmr_done) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign tmr_restart = (st_d != st_q);
  assign tmr_last    = (st_q == ST_CLKON) ? RST_LAST : GAP_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      vcc_en      <= 1'b0;
      vcc_5v      <= 1'b0;
      io_en       <= 1'b0;
      clk_en      <= 1'b0;
      card_rst    <= 1'b0;
      card_active <= 1'b0;
    end else begin
      st_q        <= st_d;
      card_active <= (st_d != ST_IDLE);
      if (st_d != st_q) begin
        case (st_d)
          ST_PWR: begin
            vcc_en <= 1'b1;
            vcc_5v <= vsel_5v;
          end
          ST_IOREL:  io_en    <= 1'b1;
          ST_CLKON:  clk_en   <= 1'b1;
          ST_ACTIVE: card_rst <= 1'b1;
          ST_DN_RST: card_rst <= 1'b0;
          ST_DN_CLK: clk_en   <= 1'b0;
          ST_DN_IO:  io_en    <= 1'b0;
          ST_IDLE:   vcc_en   <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  p_clk_needs_io_r3: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> (io_en && vcc_en));
  p_rst_needs_clk_r3: assert property (@(posedge clk) disable iff (rst)
    card_rst |-> clk_en);
  p_v5_hold_r4: assert property (@(posedge clk) disable iff (rst)
    vcc_en |=> (!vcc_en || $stable(vcc_5v)));
  p_rst_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (card_rst && (stop_req || !card_present || any_raw)) |=> !card_rst);
  p_lat_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (!vcc_en && any_lat) |=> !vcc_en);
  p_clk_after_rst_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> !card_rst);
  p_vcc_last_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en) |-> (!io_en && !clk_en && !card_rst));
  p_active_r10: assert property (@(posedge clk) disable iff (rst)
    vcc_en |-> card_active);
endmodule

// File: rtl/card_seq_top.sv
module card_seq_top
  import cs_pkg::*;
#(
  parameter int GAP_CYC = 64,
  parameter int RST_DLY = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       card_present,
  input  logic       vsel_5v,
  input  logic       vcc_good,
  input  logic       flt_overcur,
  input  logic       flt_vdd,
  input  logic       flt_vpc,
  input  logic       flt_vcc,
  input  logic       flt_hot,
  input  logic       status_rd,
  output logic       vcc_en,
  output logic       vcc_5v,
  output logic       io_en,
  output logic       clk_en,
  output logic       card_rst,
  output logic       card_active,
  output logic [4:0] fault_flags,
  output logic       irq_n
);
  localparam int MAXV = (GAP_CYC > RST_DLY) ? GAP_CYC : RST_DLY;
  localparam int CW   = $clog2(MAXV + 1);

  logic [NFLT-1:0] flt_raw;
  logic            any_raw, any_lat;
  logic            tmr_restart, tmr_done;
  logic [CW-1:0]   tmr_last;

  always_comb begin
    flt_raw         = '0;
    flt_raw[FI_OVC] = flt_overcur;
    flt_raw[FI_VDD] = flt_vdd;
    flt_raw[FI_VPC] = flt_vpc;
    flt_raw[FI_VCC] = flt_vcc;
    flt_raw[FI_HOT] = flt_hot;
  end

  cs_fault_mon #(.NF(NFLT)) u_fmon (
    .clk          (clk),
    .rst          (rst),
    .flt_raw      (flt_raw),
    .card_present (card_present),
    .status_rd    (status_rd),
    .flags        (fault_flags),
    .any_raw      (any_raw),
    .any_lat      (any_lat),
    .irq_n        (irq_n)
  );

  cs_step_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .last    (tmr_last),
    .done    (tmr_done)
  );

  cs_seq_fsm #(.GAP_CYC(GAP_CYC), .RST_DLY(RST_DLY), .CW(CW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_req    (start_req),
    .stop_req     (stop_req),
    .card_present (card_present),
    .vsel_5v      (vsel_5v),
    .vcc_good     (vcc_good),
    .any_raw      (any_raw),
    .any_lat      (any_lat),
    .tmr_done     (tmr_done),
    .tmr_restart  (tmr_restart),
    .tmr_last     (tmr_last),
    .vcc_en       (vcc_en),
    .vcc_5v       (vcc_5v),
    .io_en        (io_en),
    .clk_en       (clk_en),
    .card_rst     (card_rst),
    .card_active  (card_active)
  );
endmodule

// File: tb/sim_card_seq_top.sv
`timescale 1ns/1ps
module sim_card_seq_top;
  localparam int GAP  = 6;
  localparam int RSTD = 10;

  logic clk = 1'b0;
  logic rst, start_req, stop_req, card_present, vsel_5v, vcc_good;
  logic flt_overcur, flt_vdd, flt_vpc, flt_vcc, flt_hot, status_rd;
  logic vcc_en, vcc_5v, io_en, clk_en, card_rst, card_active, irq_n;
  logic [4:0] fault_flags;

  always #4 clk = ~clk;

  card_seq_top #(.GAP_CYC(GAP), .RST_DLY(RSTD)) u0 (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .card_present(card_present), .vsel_5v(vsel_5v), .vcc_good(vcc_good),
    .flt_overcur(flt_overcur), .flt_vdd(flt_vdd), .flt_vpc(flt_vpc),
    .flt_vcc(flt_vcc), .flt_hot(flt_hot), .status_rd(status_rd),
    .vcc_en(vcc_en), .vcc_5v(vcc_5v), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst), .card_active(card_active),
    .fault_flags(fault_flags), .irq_n(irq_n)
  );

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;

  // behavioural reference
  int   ph, mc;
  logic mvcc, mio, mclk, mrst, mv5, mact, mirqn, mpres;
  logic [4:0] mflags, raw;
  logic abort, evt;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      ph = 0; mc = 0; mvcc = 0; mio = 0; mclk = 0; mrst = 0; mv5 = 0;
      mact = 0; mflags = 0; mirqn = 1; mpres = card_present;
    end else begin
      raw   = {flt_hot, flt_vcc, flt_vpc, flt_vdd, flt_overcur};
      abort = stop_req || !card_present || (raw != 0);
      case (ph)
        0: if (start_req && card_present && mflags == 0 && raw == 0) begin
             ph = 1; mvcc = 1; mv5 = vsel_5v;
           end
        1: if (abort) begin ph = 5; mrst = 0; mc = 0; end
           else if (vcc_good) begin ph = 2; mio = 1; mc = 0; end
        2: if (abort) begin ph = 5; mrst = 0; mc = 0; end
           else if (mc == GAP - 1) begin ph = 3; mclk = 1; mc = 0; end
           else mc++;
        3: if (abort) begin ph = 5; mrst = 0; mc = 0; end
           else if (mc == RSTD - 1) begin ph = 4; mrst = 1; mc = 0; end
           else mc++;
        4: if (abort) begin ph = 5; mrst = 0; mc = 0; end
        5: if (mc == GAP - 1) begin ph = 6; mclk = 0; mc = 0; end else mc++;
        6: if (mc == GAP - 1) begin ph = 7; mio = 0; mc = 0; end else mc++;
        7: if (mc == GAP - 1) begin ph = 0; mvcc = 0; mc = 0; end else mc++;
        default: ph = 0;
      endcase
      mact   = (ph != 0);
      evt    = (raw != 0) || (card_present != mpres);
      mirqn  = !(evt || (!mirqn && !status_rd));
      mflags = raw | (mflags & {5{!status_rd}});
      mpres  = card_present;
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      nvec++;
      cmp("R3/R6 vcc_en",      32'(vcc_en),      32'(mvcc));
      cmp("R3/R6 io_en",       32'(io_en),       32'(mio));
      cmp("R3/R6 clk_en",      32'(clk_en),      32'(mclk));
      cmp("R5/R3 card_rst",    32'(card_rst),    32'(mrst));
      cmp("R4 vcc_5v",         32'(vcc_5v),      32'(mv5));
      cmp("R10 card_active",   32'(card_active), 32'(mact));
      cmp("R8 fault_flags",    32'(fault_flags), 32'(mflags));
      cmp("R9 irq_n",          32'(irq_n),       32'(mirqn));
    end
  end

  // falling-edge time stamps for spacing checks
  int t_rst, t_clk, t_io, t_vcc;
  logic pv_rst = 0, pv_clk = 0, pv_io = 0, pv_vcc = 0;
  always @(negedge clk) begin
    if (pv_rst && !card_rst) t_rst = cyc;
    if (pv_clk && !clk_en)   t_clk = cyc;
    if (pv_io  && !io_en)    t_io  = cyc;
    if (pv_vcc && !vcc_en)   t_vcc = cyc;
    pv_rst = card_rst; pv_clk = clk_en; pv_io = io_en; pv_vcc = vcc_en;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_start(logic v5);
    start_req = 1; vsel_5v = v5; @(negedge clk); start_req = 0;
  endtask
  task automatic do_stop();
    stop_req = 1; @(negedge clk); stop_req = 0;
  endtask
  task automatic do_rd();
    status_rd = 1; @(negedge clk); status_rd = 0;
  endtask
  task automatic wait_rst_high();
    for (int i = 0; i < 200; i++) begin
      if (card_rst) break;
      @(negedge clk);
    end
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (!card_active) break;
      @(negedge clk);
    end
  endtask
  task automatic clr_stamps();
    t_rst = -1; t_clk = -1; t_io = -1; t_vcc = -1;
  endtask
  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired: actual=running expected=done");
    summary();
  end

  initial begin
    rst = 1; start_req = 0; stop_req = 0; card_present = 1; vsel_5v = 0;
    vcc_good = 0; flt_overcur = 0; flt_vdd = 0; flt_vpc = 0; flt_vcc = 0;
    flt_hot = 0; status_rd = 0;
    clr_stamps();
    tick(3);
    rst = 0;
    chk("R1 vcc_en", 32'(vcc_en), 0);
    chk("R1 card_rst/clk/io", 32'({card_rst, clk_en, io_en}), 0);
    chk("R1 card_active", 32'(card_active), 0);
    chk("R1 fault_flags", 32'(fault_flags), 0);
    chk("R1 irq_n", 32'(irq_n), 1);
    tick(2);

    // normal power-up with 5 V, supply slow to settle, then host stop
    do_start(1);
    tick(4);
    chk("R3 vcc_en on while waiting", 32'(vcc_en), 1);
    chk("R3 io_en held until vcc_good", 32'(io_en), 0);
    vcc_good = 1;
    wait_rst_high();
    chk("R3 card_rst raised", 32'(card_rst), 1);
    chk("R4 vcc_5v latched", 32'(vcc_5v), 1);
    chk("R10 card_active", 32'(card_active), 1);
    clr_stamps();
    do_stop();
    wait_idle();
    tick(2);
    chk("R6 rst->clk gap", 32'(t_clk - t_rst), GAP);
    chk("R6 clk->io gap",  32'(t_io - t_clk),  GAP);
    chk("R6 io->vcc gap",  32'(t_vcc - t_io),  GAP);
    chk("R10 card_active cleared", 32'(card_active), 0);

    // 3 V start, card removal; start and stop inside shutdown are ignored
    do_start(0);
    wait_rst_high();
    chk("R4 vcc_5v low", 32'(vcc_5v), 0);
    clr_stamps();
    card_present = 0;
    tick(2);
    chk("R5 card_rst dropped on removal", 32'(card_rst), 0);
    chk("R9 irq on presence change", 32'(irq_n), 0);
    tick(2);
    do_start(1);
    do_stop();
    wait_idle();
    tick(3);
    chk("R7 no restart after shutdown", 32'(vcc_en), 0);
    chk("R7 rst->clk gap kept", 32'(t_clk - t_rst), GAP);
    chk("R7 io->vcc gap kept",  32'(t_vcc - t_io),  GAP);
    card_present = 1;
    tick(2);
    do_rd();
    chk("R9 irq released by read", 32'(irq_n), 1);

    // over-temperature pulse while active, then start while latched
    do_start(1);
    wait_rst_high();
    flt_hot = 1; tick(1); flt_hot = 0; tick(1);
    chk("R5 card_rst dropped on fault", 32'(card_rst), 0);
    chk("R8 temp flag bit 4", 32'(fault_flags), 32'h10);
    wait_idle();
    do_start(1);
    tick(3);
    chk("R2 start ignored while latched", 32'(vcc_en), 0);
    do_rd();
    chk("R8 flags cleared by read", 32'(fault_flags), 0);
    chk("R9 irq cleared by read", 32'(irq_n), 1);

    // persistent digital supply fault survives a read
    flt_vdd = 1; tick(2);
    do_rd();
    chk("R8 vdd flag held while input high", 32'(fault_flags), 32'h02);
    chk("R9 irq held while fault high", 32'(irq_n), 0);
    flt_vdd = 0; tick(1);
    do_rd();
    chk("R8 vdd flag cleared", 32'(fault_flags), 0);

    // over-current pulse while idle
    flt_overcur = 1; tick(1); flt_overcur = 0; tick(1);
    chk("R8 overcurrent flag bit 0", 32'(fault_flags), 32'h01);
    chk("R9 irq on overcurrent", 32'(irq_n), 0);
    do_rd();

    // start with no card
    card_present = 0; tick(2); do_rd();
    do_start(1);
    tick(3);
    chk("R2 start ignored without card", 32'(vcc_en), 0);
    card_present = 1; tick(2); do_rd();

    // stop while waiting for the supply
    vcc_good = 0;
    do_start(0);
    tick(3);
    do_stop();
    wait_idle();
    tick(2);
    chk("R6 shutdown from supply wait ends idle", 32'(vcc_en), 0);
    vcc_good = 1;

    // card supply fault during the reset delay
    clr_stamps();
    do_start(1);
    tick(GAP + 4);
    chk("R3 clk_en on before reset", 32'(clk_en), 1);
    flt_vcc = 1; tick(1); flt_vcc = 0;
    wait_idle();
    tick(2);
    chk("R6 clk->io gap from reset delay", 32'(t_io - t_clk), GAP);
    chk("R6 io->vcc gap from reset delay", 32'(t_vcc - t_io), GAP);
    chk("R8 card supply flag bit 3", 32'(fault_flags), 32'h08);
    do_rd();
    tick(2);
    summary();
  end
endmodule